// File: doc/BRIEF.md
# Register Vector-Tag Cascade Unit

This unit keeps the scalar/vector context of a register block that is opened by a prefix header. When the header is loaded, the unit latches the prefix's operand flags, an activation offset and a twin-mode bit. The first instruction whose in-block parcel counter equals the offset is the binding instruction. Its destination and two source register indices are stored, and each gets a tag from the prefix. In twin mode, the instruction that follows binds a second slot from a second set of prefix flags.

Every later instruction is classified operand by operand. A register that appears in a bound slot reports its stored tag. Any other register reports vector only if some bound register of that same instruction is vector. These derived classifications are never stored. A block-end pulse drops all context. The unit delivers three vector/scalar bits per instruction, registered one cycle after the instruction is presented.

Top module: `vtag_cascade`

## Requirements
- R1: With no block open, every operand is reported scalar. The result of an instruction presented with `ins_valid` high appears on the outputs, with `out_valid` high, exactly one clock later.
- R2: After a header load, instructions whose `ins_parcel` differs from `cfg_offs` are reported all scalar and bind nothing. The first instruction with `ins_parcel == cfg_offs` is the binding instruction.
- R3: The binding instruction reports the slot-0 prefix flags. The flag order is bit 2 = destination, bit 1 = source 1, bit 0 = source 2. A flag whose `cfg_has` bit is 0 takes the OR of the present flags of the same slot, or 0 if none are present.
- R4: A register that appears in a bound slot reports its bound tag in every later instruction of the block, whatever the other operands are.
- R5: A register not in any bound slot reports vector if at least one bound register among the same instruction's operands is vector. If none is, it reports scalar.
- R6: OR-derived classifications are not stored. A register reported scalar in one instruction may be reported vector in a later one.
- R7: In twin mode (`cfg_twin`=1), the instruction after the binding instruction reports the slot-1 flags (bits 5:3, same order and implicit rule) and binds slot 1. If a register is in both slots, the slot-0 tag wins.
- R8: `blk_end` clears all context, so later instructions report all scalar until the next header load. If `cfg_load` and `blk_end` arrive in the same cycle, the load wins.
- R9: Register index 0 is always reported scalar and never counts as bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Header load strobe; opens a block |
| cfg_twin | input | 1 | Twin mode: a second slot binds the next instruction |
| cfg_offs | input | PW | Activation offset in 16-bit parcels |
| cfg_has | input | 6 | Flag-present bits, slot 1 in [5:3], slot 0 in [2:0] |
| cfg_tag | input | 6 | Flag values, same layout as cfg_has |
| blk_end | input | 1 | Block end; discards all tags |
| ins_valid | input | 1 | Instruction present |
| ins_parcel | input | PW | In-block parcel counter of the instruction |
| ins_rd | input | RW | Destination register index |
| ins_rs1 | input | RW | Source 1 register index |
| ins_rs2 | input | RW | Source 2 register index |
| out_valid | output | 1 | Classification valid |
| out_vd | output | 1 | Destination is vector |
| out_vs1 | output | 1 | Source 1 is vector |
| out_vs2 | output | 1 | Source 2 is vector |

## Verification
The bench replays the cascade example. A register such as x4 is reported scalar when no bound operand sits beside it, then vector when a bound vector register does. A design that stored derived tags would report it scalar the second time. Instructions before the activation offset are sent with registers that are later bound. A unit that bound early, or that compared with greater-or-equal, would give different tags. Twin mode is driven with one register placed in both slots, so a design with the wrong slot priority reports the wrong tag for it. Further instructions use x0, follow a block end, and have flags missing, which exposes a broken implicit-OR rule or a missing clear.

// File: rtl/vtag_cascade.sv
module vtag_cascade #(
  parameter int RW = 5,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_twin,
  input  logic [PW-1:0] cfg_offs,
  input  logic [5:0]    cfg_has,
  input  logic [5:0]    cfg_tag,
  input  logic          blk_end,
  input  logic          ins_valid,
  input  logic [PW-1:0] ins_parcel,
  input  logic [RW-1:0] ins_rd,
  input  logic [RW-1:0] ins_rs1,
  input  logic [RW-1:0] ins_rs2,
  output logic          out_valid,
  output logic          out_vd,
  output logic          out_vs1,
  output logic          out_vs2
);

  typedef enum logic [1:0] {IDLE, WAIT, BIND2, RUN} st_t;

  st_t                  st;
  logic [PW-1:0]        offs_q;
  logic                 twin_q;
  logic [5:0]           eff_q;
  logic [2:0][RW-1:0]   idx0, idx1;
  logic                 bnd1;
  logic [2:0]           cls;

  function automatic logic [2:0] implicit_fill(input logic [2:0] has, input logic [2:0] tg);
    logic any;
    any = |(has & tg);
    for (int i = 0; i < 3; i++) implicit_fill[i] = has[i] ? tg[i] : any;
  endfunction

  // returns {bound, tag}
  function automatic logic [1:0] lookup(input logic [RW-1:0] r);
    logic [1:0] res;
    res = 2'b00;
    if (r != '0) begin
      for (int i = 2; i >= 0; i--)
        if (!res[1] && idx0[i] == r) res = {1'b1, eff_q[i]};
      for (int i = 2; i >= 0; i--)
        if (!res[1] && bnd1 && idx1[i] == r) res = {1'b1, eff_q[3+i]};
    end
    return res;
  endfunction

  logic [2:0] nz;
  logic [1:0] l_rd, l_rs1, l_rs2;
  logic       any_vec;
  logic       hit;

  assign nz      = {ins_rd != '0, ins_rs1 != '0, ins_rs2 != '0};
  assign l_rd    = lookup(ins_rd);
  assign l_rs1   = lookup(ins_rs1);
  assign l_rs2   = lookup(ins_rs2);
  assign any_vec = (&l_rd) | (&l_rs1) | (&l_rs2);
  assign hit     = ins_parcel == offs_q;

  always_comb begin
    unique case (st)
      WAIT:    cls = hit ? eff_q[2:0] : 3'b000;
      BIND2:   cls = eff_q[5:3];
      RUN:     cls = {l_rd[1]  ? l_rd[0]  : any_vec,
                      l_rs1[1] ? l_rs1[0] : any_vec,
                      l_rs2[1] ? l_rs2[0] : any_vec};
      default: cls = 3'b000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      offs_q <= '0;
      twin_q <= 1'b0;
      eff_q  <= '0;
      idx0   <= '0;
      idx1   <= '0;
      bnd1   <= 1'b0;
    end else if (cfg_load) begin
      st     <= WAIT;
      offs_q <= cfg_offs;
      twin_q <= cfg_twin;
      eff_q  <= {implicit_fill(cfg_has[5:3], cfg_tag[5:3]),
                 implicit_fill(cfg_has[2:0], cfg_tag[2:0])};
      idx0   <= '0;
      idx1   <= '0;
      bnd1   <= 1'b0;
    end else if (blk_end) begin
      st     <= IDLE;
      idx0   <= '0;
      idx1   <= '0;
      bnd1   <= 1'b0;
    end else if (ins_valid) begin
      if (st == WAIT && hit) begin
        idx0 <= {ins_rd, ins_rs1, ins_rs2};
        st   <= twin_q ? BIND2 : RUN;
      end else if (st == BIND2) begin
        idx1 <= {ins_rd, ins_rs1, ins_rs2};
        bnd1 <= 1'b1;
        st   <= RUN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      {out_vd, out_vs1, out_vs2} <= 3'b000;
    end else begin
      out_valid <= ins_valid;
      {out_vd, out_vs1, out_vs2} <= ins_valid ? (cls & nz) : 3'b000;
    end
  end

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |=> out_valid);
  // R1
  idle_scalar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && st == IDLE) |=> !(out_vd || out_vs1 || out_vs2));
  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_rd == '0) |=> !out_vd);
  // R8
  end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && !cfg_load) |=> (st == IDLE && !bnd1));
  // R4
  bound_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RUN && !cfg_load && !blk_end) |=> ($stable(idx0) && $stable(idx1) && $stable(eff_q)));
  // R2
  early_scalar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && st == WAIT && ins_parcel != offs_q) |=> !(out_vd || out_vs1 || out_vs2));

endmodule

// File: tb/vtag_cascade_tb.sv
module vtag_cascade_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 0, cfg_twin = 0, blk_end = 0, ins_valid = 0;
  logic [4:0] cfg_offs = 0, ins_parcel = 0, ins_rd = 0, ins_rs1 = 0, ins_rs2 = 0;
  logic [5:0] cfg_has = 0, cfg_tag = 0;
  logic out_valid, out_vd, out_vs1, out_vs2;

  int checks = 0, fails = 0;
  logic [2:0] exp_q[$];
  string      req_q[$];
  bit         done = 0;

  always #5 clk = ~clk;

  vtag_cascade u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_twin(cfg_twin),
    .cfg_offs(cfg_offs), .cfg_has(cfg_has), .cfg_tag(cfg_tag), .blk_end(blk_end),
    .ins_valid(ins_valid), .ins_parcel(ins_parcel), .ins_rd(ins_rd),
    .ins_rs1(ins_rs1), .ins_rs2(ins_rs2), .out_valid(out_valid),
    .out_vd(out_vd), .out_vs1(out_vs1), .out_vs2(out_vs2));

  task automatic header(input logic twin, input logic [4:0] offs,
                        input logic [5:0] has, input logic [5:0] tg);
    @(posedge clk); #1;
    ins_valid = 0; cfg_load = 1; cfg_twin = twin; cfg_offs = offs;
    cfg_has = has; cfg_tag = tg;
    @(posedge clk); #1;
    cfg_load = 0;
  endtask

  task automatic finish_block();
    @(posedge clk); #1;
    ins_valid = 0; blk_end = 1;
    @(posedge clk); #1;
    blk_end = 0;
  endtask

  task automatic send(input logic [4:0] pc, input logic [4:0] rd, input logic [4:0] r1,
                      input logic [4:0] r2, input logic [2:0] exp, input string req);
    @(posedge clk); #1;
    ins_valid = 1; ins_parcel = pc; ins_rd = rd; ins_rs1 = r1; ins_rs2 = r2;
    exp_q.push_back(exp); req_q.push_back(req);
  endtask

  task automatic idle_ins();
    @(posedge clk); #1;
    ins_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected output: actual %b expected none", {out_vd, out_vs1, out_vs2});
      end else begin
        logic [2:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if ({out_vd, out_vs1, out_vs2} !== e) begin
          fails++;
          $display("FAIL %s: actual %b expected %b", r, {out_vd, out_vs1, out_vs2}, e);
        end
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    checks++;
    if ({out_valid, out_vd, out_vs1, out_vs2} !== 4'b0000) begin
      fails++;
      $display("FAIL R1 reset: actual %b expected 0000", {out_valid, out_vd, out_vs1, out_vs2});
    end

    // R1: no block open
    send(0, 3, 5, 12, 3'b000, "R1 idle");
    idle_ins();

    // Cascade example: vs1=1, vs2=0 present, vd absent -> vd=1 (R3)
    header(0, 0, 6'b000_011, 6'b000_010);
    send(0, 3, 5, 12, 3'b110, "R3 bind implicit vd");
    send(2, 7, 5, 3, 3'b111, "R5 OR of bound");
    send(4, 9, 4, 4, 3'b000, "R5 none bound");
    send(6, 7, 5, 4, 3'b111, "R6 x4 now vector");
    send(8, 12, 12, 6, 3'b000, "R4 bound scalar kept");
    send(10, 6, 3, 12, 3'b110, "R4 scalar x12 beside vector");
    send(12, 0, 5, 3, 3'b011, "R9 x0 scalar");
    send(14, 3, 0, 0, 3'b100, "R9 x0 not bound");
    finish_block();
    send(0, 7, 5, 3, 3'b000, "R8 after end");
    idle_ins();

    // Offset 4: slot0 only vs2=1 present -> all 1 (R3); early instrs untagged (R2)
    header(0, 4, 6'b000_001, 6'b000_001);
    send(0, 3, 5, 12, 3'b000, "R2 before offset");
    send(2, 8, 9, 10, 3'b000, "R2 before offset");
    send(4, 8, 9, 10, 3'b111, "R2 R3 bind at offset");
    send(6, 3, 5, 12, 3'b000, "R2 early regs not bound");
    send(8, 3, 9, 4, 3'b111, "R5 cascade from x9");
    send(4, 3, 5, 12, 3'b000, "R2 no rebind at offset");
    idle_ins();
    // R8: load wins over end in the same cycle
    @(posedge clk); #1;
    cfg_load = 1; blk_end = 1; cfg_twin = 0; cfg_offs = 0;
    cfg_has = 6'b000_111; cfg_tag = 6'b000_101;
    @(posedge clk); #1;
    cfg_load = 0; blk_end = 0;
    send(0, 3, 5, 12, 3'b101, "R8 load beats end");
    finish_block();

    // Twin: slot0 {0,1,0} all present, slot1 all present 0; x5 in both slots
    header(1, 0, 6'b111_111, 6'b000_010);
    send(0, 3, 5, 12, 3'b010, "R7 slot0 bind");
    send(2, 5, 6, 7, 3'b000, "R7 slot1 bind");
    send(4, 9, 5, 6, 3'b110, "R7 slot0 wins for x5");
    send(6, 9, 6, 7, 3'b000, "R7 slot1 scalars");
    send(8, 3, 20, 21, 3'b000, "R5 bound scalar only");
    send(10, 20, 21, 5, 3'b111, "R5 x5 vector spreads");
    finish_block();
    repeat (3) @(posedge clk);

    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R1 missing outputs: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule